// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block sits in the core clock domain behind a serial byte receiver. Bytes arrive one at a time, each marked by a single-cycle valid strobe. The block groups them into commands of two to four frames, chosen by the first byte. It turns each finished command into strobes for an external register file (address, write data, write strobe, read strobe) and for an external ALU (function code, evaluate strobe, clock-gate enable).

There are four command codes. A register write takes three frames: the code, then the address, then the data. A register read takes two frames: the code, then the address. An ALU command that carries operands takes four frames: the code, operand A, operand B and the function. The operands go into registers 0 and 1 through the ordinary write path. An ALU command without operands takes two frames, the code and the function, and it works on whatever registers 0 and 1 already hold.

An enable input, driven from the transmit side, freezes frame acceptance while a reply is being sent. Frames that arrive during that time are lost.

Top module: `cmd_frame_decoder`

## Requirements
- R1: A synchronous active-high reset puts the parser in its idle state. After the first clock edge with reset high, `rf_wr_en`, `rf_rd_en`, `alu_en` and `alu_gate_en` are low and `rf_addr`, `rf_wr_data` and `alu_func` are zero.
- R2: A frame sequence 0xAA, address, data raises `rf_wr_en` for one cycle. This happens in the cycle after the data frame is accepted. In that cycle `rf_addr` equals bits [3:0] of the address frame and `rf_wr_data` equals the data frame.
- R3: A frame sequence 0xBB, address raises `rf_rd_en` for one cycle, in the cycle after the address frame is accepted. `rf_addr` equals bits [3:0] of the address frame, and no write strobe is raised.
- R4: A frame sequence 0xCC, A, B, function produces three actions, each in the cycle after its frame is accepted. Frame A gives a one-cycle write of A to register address 0. Frame B gives a one-cycle write of B to register address 1. The function frame gives the ALU evaluate described in R5.
- R5: A frame sequence 0xDD, function raises `alu_en` for one cycle, in the cycle after the function frame is accepted, with `alu_func` equal to bits [3:0] of that frame. No register strobe is raised.
- R6: `alu_gate_en` is high in the cycle in which `alu_en` is high and in the one cycle after it, and low in the cycle after that. Frames that arrive in those two cycles are discarded.
- R7: A frame presented while `proc_en` is low is ignored. This holds both at the start of a command and partway through one. The command resumes with the next frame accepted after `proc_en` returns high.
- R8: A first frame other than 0xAA, 0xBB, 0xCC or 0xDD is discarded and the parser stays idle, so the next frame is taken as a command code.
- R9: At most one of `rf_wr_en`, `rf_rd_en` and `alu_en` is high in any cycle. Each strobe pulse stands for exactly one action: one per register write, one per read, one per ALU evaluate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| proc_en | input | 1 | Frame acceptance enable from the transmit side |
| rf_addr | output | 4 | Register file address |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_data | output | 8 | Register file write data |
| rf_rd_en | output | 1 | Register file read strobe |
| alu_func | output | 4 | ALU function code |
| alu_en | output | 1 | ALU evaluate strobe |
| alu_gate_en | output | 1 | ALU clock-gate enable |

## Verification
The hardest states to reach from the ports are the two cycles after an ALU evaluate. There the parser drops frames even though acceptance is enabled. The bench reaches them by holding `rx_valid` high with a read code right after the function frame, and then proves the read code was lost. A second case is a command left half-parsed while `proc_en` is low; the bench pauses between the code and the address frame. Every non-command first byte is swept, and each is followed by a read to show that the parser stayed idle.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned FUNC_W = 4;

    localparam logic [DATA_W-1:0] OPC_REG_WRITE = 8'hAA;
    localparam logic [DATA_W-1:0] OPC_REG_READ  = 8'hBB;
    localparam logic [DATA_W-1:0] OPC_ALU_LOAD  = 8'hCC;
    localparam logic [DATA_W-1:0] OPC_ALU_HELD  = 8'hDD;

    localparam logic [ADDR_W-1:0] OPERAND_A_REG = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OPERAND_B_REG = ADDR_W'(1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_ADDR,
        ST_WR_DATA,
        ST_RD_ADDR,
        ST_OP_A,
        ST_OP_B,
        ST_FUNC,
        ST_EVAL,
        ST_SETTLE
    } dec_state_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              alu;
        logic              gate;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [FUNC_W-1:0] func;
    } ctl_req_t;

    function automatic logic is_opcode(input logic [DATA_W-1:0] b);
        return (b == OPC_REG_WRITE) || (b == OPC_REG_READ) ||
               (b == OPC_ALU_LOAD)  || (b == OPC_ALU_HELD);
    endfunction

    function automatic dec_state_e entry_state(input logic [DATA_W-1:0] b);
        dec_state_e s;
        case (b)
            OPC_REG_WRITE: s = ST_WR_ADDR;
            OPC_REG_READ:  s = ST_RD_ADDR;
            OPC_ALU_LOAD:  s = ST_OP_A;
            OPC_ALU_HELD:  s = ST_FUNC;
            default:       s = ST_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic waits_for_frame(input dec_state_e s);
        return (s != ST_EVAL) && (s != ST_SETTLE);
    endfunction

endpackage

// File: rtl/cfd_fsm.sv
module cfd_fsm
    import cfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              proc_en,
    output ctl_req_t          req,
    output dec_state_e        state
);

    dec_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_hold_q, addr_hold_d;
    logic              accept;

    assign accept = rx_valid && proc_en;
    assign state  = state_q;

    always_comb begin
        state_d     = state_q;
        addr_hold_d = addr_hold_q;
        req         = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept) state_d = entry_state(rx_byte);
            end
            ST_WR_ADDR: begin
                if (accept) begin
                    addr_hold_d = rx_byte[ADDR_W-1:0];
                    state_d     = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                if (accept) begin
                    req.wr   = 1'b1;
                    req.addr = addr_hold_q;
                    req.data = rx_byte;
                    state_d  = ST_IDLE;
                end
            end
            ST_RD_ADDR: begin
                if (accept) begin
                    req.rd   = 1'b1;
                    req.addr = rx_byte[ADDR_W-1:0];
                    state_d  = ST_IDLE;
                end
            end
            ST_OP_A: begin
                if (accept) begin
                    req.wr   = 1'b1;
                    req.addr = OPERAND_A_REG;
                    req.data = rx_byte;
                    state_d  = ST_OP_B;
                end
            end
            ST_OP_B: begin
                if (accept) begin
                    req.wr   = 1'b1;
                    req.addr = OPERAND_B_REG;
                    req.data = rx_byte;
                    state_d  = ST_FUNC;
                end
            end
            ST_FUNC: begin
                if (accept) begin
                    req.alu  = 1'b1;
                    req.gate = 1'b1;
                    req.func = rx_byte[FUNC_W-1:0];
                    state_d  = ST_EVAL;
                end
            end
            ST_EVAL: begin
                req.gate = 1'b1;
                state_d  = ST_SETTLE;
            end
            ST_SETTLE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_hold_q <= '0;
        end else begin
            state_q     <= state_d;
            addr_hold_q <= addr_hold_d;
        end
    end

    AST_PAUSE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        (!proc_en && waits_for_frame(state_q)) |=> (state_q == $past(state_q))); // R7
    AST_UNKNOWN_OPCODE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && rx_valid && proc_en && !is_opcode(rx_byte)) |=> (state_q == ST_IDLE)); // R8
    AST_EVAL_TO_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL) |=> (state_q == ST_SETTLE)); // R6
    AST_SETTLE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE) |=> (state_q == ST_IDLE)); // R6

endmodule

// File: rtl/cfd_out_stage.sv
module cfd_out_stage
    import cfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_req_t          req,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              rf_rd_en,
    output logic [FUNC_W-1:0] alu_func,
    output logic              alu_en,
    output logic              alu_gate_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_addr     <= '0;
            rf_wr_en    <= 1'b0;
            rf_wr_data  <= '0;
            rf_rd_en    <= 1'b0;
            alu_func    <= '0;
            alu_en      <= 1'b0;
            alu_gate_en <= 1'b0;
        end else begin
            rf_wr_en    <= req.wr;
            rf_rd_en    <= req.rd;
            alu_en      <= req.alu;
            alu_gate_en <= req.gate;
            if (req.wr || req.rd) rf_addr    <= req.addr;
            if (req.wr)           rf_wr_data <= req.data;
            if (req.alu)          alu_func   <= req.func;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!rf_wr_en && !rf_rd_en && !alu_en && !alu_gate_en)); // R1
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_wr_en, rf_rd_en, alu_en})); // R9
    AST_GATE_WITH_ALU: assert property (@(posedge clk) disable iff (rst)
        alu_en |-> alu_gate_en); // R6
    AST_GATE_STRETCH: assert property (@(posedge clk) disable iff (rst)
        alu_en |=> (alu_gate_en && !alu_en)); // R6
    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |=> !rf_rd_en); // R3

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
    import cfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              proc_en,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              rf_rd_en,
    output logic [FUNC_W-1:0] alu_func,
    output logic              alu_en,
    output logic              alu_gate_en
);

    ctl_req_t   req;
    dec_state_e state;

    cfd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .proc_en  (proc_en),
        .req      (req),
        .state    (state)
    );

    cfd_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .rf_addr     (rf_addr),
        .rf_wr_en    (rf_wr_en),
        .rf_wr_data  (rf_wr_data),
        .rf_rd_en    (rf_rd_en),
        .alu_func    (alu_func),
        .alu_en      (alu_en),
        .alu_gate_en (alu_gate_en)
    );

    AST_GATE_ONLY_AROUND_EVAL: assert property (@(posedge clk) disable iff (rst)
        (alu_gate_en && !alu_en) |-> (state == ST_SETTLE)); // R6

endmodule

// File: tb/cmd_frame_decoder_tb_top.sv
module cmd_frame_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       proc_en = 1'b1;
    logic [3:0] rf_addr;
    logic       rf_wr_en;
    logic [7:0] rf_wr_data;
    logic       rf_rd_en;
    logic [3:0] alu_func;
    logic       alu_en;
    logic       alu_gate_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cnt_wr = 0, cnt_rd = 0, cnt_alu = 0;
    int exp_wr = 0, exp_rd = 0, exp_alu = 0;

    always #5 clk = ~clk;

    cmd_frame_decoder dut_i (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .proc_en     (proc_en),
        .rf_addr     (rf_addr),
        .rf_wr_en    (rf_wr_en),
        .rf_wr_data  (rf_wr_data),
        .rf_rd_en    (rf_rd_en),
        .alu_func    (alu_func),
        .alu_en      (alu_en),
        .alu_gate_en (alu_gate_en)
    );

    always @(negedge clk) begin
        if (rst) begin
            cnt_wr = 0; cnt_rd = 0; cnt_alu = 0;
        end else begin
            cnt_wr  = cnt_wr  + int'(rf_wr_en);
            cnt_rd  = cnt_rd  + int'(rf_rd_en);
            cnt_alu = cnt_alu + int'(alu_en);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One frame; returns at the negedge after the accepting edge.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 strobes", {rf_wr_en, rf_rd_en, alu_en, alu_gate_en}, 0);
        chk("R1 addr/data/func", {rf_addr, rf_wr_data, alu_func}, 0);

        // R2 / R3 sweep over all addresses
        for (int a = 0; a < 16; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 5) & 255);
            send(8'hAA); send({4'(a ^ 9), 4'(a)}); send(d);
            exp_wr++;
            chk("R2 wr_en", rf_wr_en, 1);
            chk("R2 addr", rf_addr, a);
            chk("R2 data", rf_wr_data, d);
            idle_cycles(1);
            chk("R2 single pulse", rf_wr_en, 0);
            send(8'hBB); send({4'(a ^ 5), 4'(a)});
            exp_rd++;
            chk("R3 rd_en", rf_rd_en, 1);
            chk("R3 addr", rf_addr, a);
            chk("R3 no write", rf_wr_en, 0);
            idle_cycles(1);
            chk("R3 single pulse", rf_rd_en, 0);
        end

        // R5 / R6 sweep over all functions
        for (int f = 0; f < 16; f++) begin
            send(8'hDD); send({4'hA, 4'(f)});
            exp_alu++;
            chk("R5 alu_en", alu_en, 1);
            chk("R5 func", alu_func, f);
            chk("R5 no reg strobe", {rf_wr_en, rf_rd_en}, 0);
            chk("R6 gate with eval", alu_gate_en, 1);
            idle_cycles(1);
            chk("R6 gate stretched", {alu_gate_en, alu_en}, 2'b10);
            idle_cycles(1);
            chk("R6 gate released", alu_gate_en, 0);
        end

        // R4 operand-loading command
        for (int k = 0; k < 4; k++) begin
            logic [7:0] oa, ob;
            oa = 8'(k * 61 + 3);
            ob = 8'(255 - k * 17);
            send(8'hCC);
            send(oa);
            exp_wr++;
            chk("R4 A write", {rf_wr_en, rf_addr, rf_wr_data}, {1'b1, 4'd0, oa});
            send(ob);
            exp_wr++;
            chk("R4 B write", {rf_wr_en, rf_addr, rf_wr_data}, {1'b1, 4'd1, ob});
            send(8'(8'h50 + k));
            exp_alu++;
            chk("R4 eval", {alu_en, rf_wr_en, alu_func}, {1'b1, 1'b0, 4'(k)});
            idle_cycles(2);
        end

        // R6 frames during the two gate cycles are dropped
        send(8'hDD); send(8'h03);
        exp_alu++;
        rx_valid = 1'b1; rx_byte = 8'hBB;
        @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        send(8'h05);
        chk("R6 dropped frames", {rf_rd_en, rf_wr_en, alu_en}, 0);
        send(8'hBB); send(8'h09);
        exp_rd++;
        chk("R6 idle after settle", {rf_rd_en, rf_addr}, {1'b1, 4'd9});

        // R7 pause at command start
        proc_en = 1'b0;
        send(8'hAA); send(8'h03); send(8'h77);
        chk("R7 paused no write", rf_wr_en, 0);
        proc_en = 1'b1;
        send(8'h04);
        chk("R7 still idle", {rf_wr_en, rf_rd_en}, 0);
        // R7 pause mid-command
        send(8'hAA);
        proc_en = 1'b0;
        send(8'h06);
        proc_en = 1'b1;
        send(8'h08); send(8'h22);
        exp_wr++;
        chk("R7 resumed write", {rf_wr_en, rf_addr, rf_wr_data}, {1'b1, 4'd8, 8'h22});

        // R8 sweep of every non-command first byte
        for (int b = 0; b < 256; b++) begin
            if (b == 8'hAA || b == 8'hBB || b == 8'hCC || b == 8'hDD) continue;
            send(8'(b));
            chk("R8 no action", {rf_wr_en, rf_rd_en, alu_en}, 0);
            send(8'hBB); send(8'(b));
            exp_rd++;
            chk("R8 parser idle", {rf_rd_en, rf_addr}, {1'b1, 4'(b)});
        end

        // R9 pulse totals
        idle_cycles(3);
        chk("R9 write pulses", cnt_wr, exp_wr);
        chk("R9 read pulses", cnt_rd, exp_rd);
        chk("R9 alu pulses", cnt_alu, exp_alu);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-R9 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule